// File: doc/BRIEF.md
# Dual-Enable Static Memory Core

A functional, fully synchronous model of an 8,192-word by 8-bit static memory whose control port behaves like an asynchronous pin interface. The pins are two chip selects of opposite polarity, a write strobe, an output enable, a 13-bit address and an 8-bit input data bus. The block samples them on a fast system clock. All inputs pass through a two-stage synchroniser. A mode decoder then picks one of four modes: standby, output-off, read or write. The array sits behind the decoder.

A write is the overlap of three conditions: the active-low select is low, the active-high select is high and the write strobe is low. Any one of the three can end the overlap by going inactive. When the overlap ends, the block stores the address and data that it sampled in the last clock cycle of the overlap. A change that arrives together with the terminating edge therefore has no effect. The three-state pad is modelled by a plain data-out bus and a data-out enable. The enable is high only in read mode.

This port carries no streaming traffic, so every pin is a plain level-sensitive control or data signal. There is no valid/ready handshake and no back-pressure.

Top module: `dualsel_sram`

## Requirements
- R1: The array holds 2^13 independent 8-bit words, selected by the 13-bit address. Both address 0 and address 8191 store and return their own data.
- R2: The part is in standby when `cs_n_i` is 1 or `cs_i` is 0. In standby `dout_en_o` is 0, and a low `we_n_i` changes no stored word.
- R3: When selected with `we_n_i`=1 and `oe_n_i`=1, the mode is output-off and `dout_en_o` is 0.
- R4: When selected with `we_n_i`=1 and `oe_n_i`=0, the mode is read. `dout_en_o` is 1 and `dout_o` shows the word at the address. Outputs reflect the pin levels sampled two clock edges earlier.
- R5: When selected with `we_n_i`=0, the mode is write whatever the level of `oe_n_i`, and `dout_en_o` is 0.
- R6: A write takes place only while all three write conditions hold. Releasing any one of them (`we_n_i` to 1, `cs_n_i` to 1 or `cs_i` to 0) commits the write.
- R7: The stored address and data are those sampled in the last cycle of the overlap. An address or data change made together with the terminating edge is ignored.
- R8: Reset forces `dout_en_o` to 0 and leaves the array contents unchanged.
- R9: If `we_n_i` falls first and the selects become active afterwards, `dout_en_o` stays 0 throughout, and the write still commits when the overlap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Word address |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Word at the sampled address |
| dout_en_o | output | 1 | High when the data bus would be driven (read mode) |

## Verification
The assertions assume that every pin is a clean level at each sampling edge. They also assume that an output follows the pins exactly two edges later, so they relate `dout_en_o` to the pin values of two cycles before and to nothing else. The bench meets both assumptions by changing pins only on the falling clock edge. It holds every level for at least three rising edges before the next change. It reads only addresses it has already written, so the reference model always knows the expected word.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUTOFF  = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } dsr_mode_e;

  // control bundle bit positions inside the synchronised vector
  localparam int unsigned CTL_CSN = 0;
  localparam int unsigned CTL_CS  = 1;
  localparam int unsigned CTL_WEN = 2;
  localparam int unsigned CTL_OEN = 3;
  localparam int unsigned CTL_W   = 4;
  // idle level: deselected, no write, output off
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1101;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    din_i,
  output dsr_mode_e        mode_o,
  output logic             wr_stb_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o
);
  logic selected, wr_cond, wr_cond_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;

  assign selected = !ctl_i[CTL_CSN] && ctl_i[CTL_CS];
  assign wr_cond  = selected && !ctl_i[CTL_WEN];

  always_comb begin
    if (!selected)           mode_o = MODE_STANDBY;
    else if (!ctl_i[CTL_WEN]) mode_o = MODE_WRITE;
    else if (!ctl_i[CTL_OEN]) mode_o = MODE_READ;
    else                     mode_o = MODE_OUTOFF;
  end

  // one-cycle history of the overlap and of the write operands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cond_q <= 1'b0;
      addr_q    <= '0;
      din_q     <= '0;
    end else begin
      wr_cond_q <= wr_cond;
      addr_q    <= addr_i;
      din_q     <= din_i;
    end
  end

  // falling edge of the overlap: commit what was seen while it still held
  assign wr_stb_o  = wr_cond_q && !wr_cond;
  assign wr_addr_o = addr_q;
  assign wr_data_o = din_q;
endmodule

// File: rtl/dsr_array.sv
module dsr_array #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // no reset: contents survive reset
  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dualsel_sram.sv
module dualsel_sram
  import dsr_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          cs_n_i,
  input  logic          cs_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o
);
  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic [AW-1:0]    addr_s, wr_addr;
  logic [DW-1:0]    din_s, wr_data;
  dsr_mode_e        mode;
  logic             wr_stb;

  always_comb begin
    ctl_raw          = '0;
    ctl_raw[CTL_CSN] = cs_n_i;
    ctl_raw[CTL_CS]  = cs_i;
    ctl_raw[CTL_WEN] = we_n_i;
    ctl_raw[CTL_OEN] = oe_n_i;
  end

  dsr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s));
  dsr_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d_i(addr_i), .q_o(addr_s));
  dsr_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d_i(din_i), .q_o(din_s));

  dsr_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s), .addr_i(addr_s), .din_i(din_s),
    .mode_o(mode), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  dsr_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we_i(wr_stb), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(addr_s), .rdata_o(dout_o));

  assign dout_en_o = (mode == MODE_READ);
endmodule

// File: rtl/dualsel_sram_chk.sv
module dualsel_sram_chk #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_i,
  input logic          cs_n_i,
  input logic          cs_i,
  input logic          we_n_i,
  input logic          oe_n_i,
  input logic [DW-1:0] din_i,
  input logic [DW-1:0] dout_o,
  input logic          dout_en_o
);
  p_standby_csn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i, 2) |-> !dout_en_o);
  p_standby_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_i, 2) |-> !dout_en_o);
  p_outoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n_i, 2) |-> !dout_en_o);
  p_read_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1) && !$past(cs_n_i, 2) && $past(cs_i, 2)
     && $past(we_n_i, 2) && !$past(oe_n_i, 2)) |-> dout_en_o);
  p_write_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_n_i, 2) |-> !dout_en_o);
endmodule

bind dualsel_sram dualsel_sram_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_dualsel_sram.sv
`timescale 1ns/1ps
module sim_dualsel_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        cs_n = 1'b1, cs = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] ref_mem [8192];

  always #4 clk = ~clk;

  dualsel_sram u0 (.clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n), .cs_i(cs),
    .we_n_i(we_n), .oe_n_i(oe_n), .din_i(din), .dout_o(dout), .dout_en_o(dout_en));

  function automatic logic [12:0] pool(input int i);
    return 13'(i * 129);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 1'b1; cs = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    settle();
  endtask

  // term: 0 write strobe ends, 1 low select ends, 2 high select ends
  task automatic do_write(input logic [12:0] a, input logic [7:0] d, input int term,
                          input bit glitch, input bit late, input logic [12:0] ga);
    addr = a; din = d; oe_n = 1'($urandom % 2);
    if (late) begin
      we_n = 1'b0; settle();
      chk("R9 enable before select", {7'b0, dout_en}, 8'h00);
      cs_n = 1'b0; cs = 1'b1; settle();
      chk("R9 enable after late select", {7'b0, dout_en}, 8'h00);
    end else begin
      cs_n = 1'b0; cs = 1'b1; settle();
      we_n = 1'b0; settle();
      chk("R5 write mode enable", {7'b0, dout_en}, 8'h00);
    end
    case (term)
      0: we_n = 1'b1;
      1: cs_n = 1'b1;
      default: cs = 1'b0;
    endcase
    if (glitch) begin addr = ga; din = ~d; end
    settle();
    ref_mem[a] = d;
    go_idle();
  endtask

  task automatic do_read(input logic [12:0] a, input string req);
    addr = a; cs_n = 1'b0; cs = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    settle();
    chk(req, {7'b0, dout_en}, 8'h01);
    chk(req, dout, ref_mem[a]);
    go_idle();
  endtask

  task automatic stby_write(input logic [12:0] a, input bit which);
    addr = a; din = ~ref_mem[a]; oe_n = 1'b0; we_n = 1'b0;
    if (which) begin cs_n = 1'b1; cs = 1'b1; end
    else begin cs_n = 1'b0; cs = 1'b0; end
    settle();
    chk("R2 standby enable", {7'b0, dout_en}, 8'h00);
    go_idle();
    do_read(a, "R2 standby write ignored");
  endtask

  task automatic out_off(input logic [12:0] a);
    addr = a; cs_n = 1'b0; cs = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    settle();
    chk("R3 output-off enable", {7'b0, dout_en}, 8'h00);
    go_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk("R8 reset enable", {7'b0, dout_en}, 8'h00);
    rst_n = 1'b1;
    settle();
    chk("R8 idle enable", {7'b0, dout_en}, 8'h00);

    for (int i = 0; i < 64; i++)
      do_write(pool(i), 8'($urandom), i % 3, 1'b0, 1'b0, '0);

    // R1 address extremes
    do_write(13'd0, 8'hA5, 0, 1'b0, 1'b0, '0);
    do_write(13'd8191, 8'h3C, 1, 1'b0, 1'b0, '0);
    do_read(13'd0, "R1 address 0");
    do_read(13'd8191, "R1 address 8191");
    for (int i = 0; i < 64; i += 9) do_read(pool(i), "R1 pool word");

    // R6 each terminating control
    for (int t = 0; t < 3; t++) begin
      do_write(pool(10 + t), 8'(8'h50 + t), t, 1'b0, 1'b0, '0);
      do_read(pool(10 + t), "R6 terminating control");
    end

    // R7 changes coincident with termination
    for (int t = 0; t < 3; t++) begin
      do_write(pool(20 + t), 8'(8'h71 + t), t, 1'b1, 1'b0, pool(30 + t));
      do_read(pool(20 + t), "R7 data at end of overlap");
      do_read(pool(30 + t), "R7 glitch address untouched");
    end

    // R9 late select
    do_write(pool(40), 8'hC9, 2, 1'b0, 1'b1, '0);
    do_read(pool(40), "R9 late select write");

    stby_write(pool(41), 1'b1);
    stby_write(pool(42), 1'b0);
    out_off(pool(43));

    // R8 reset keeps contents
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 enable in reset", {7'b0, dout_en}, 8'h00);
    rst_n = 1'b1; settle();
    do_read(pool(3), "R8 contents kept");

    for (int n = 0; n < 300; n++) begin
      int op = int'($urandom % 5);
      int i = int'($urandom % 64);
      case (op)
        0, 1: do_read(pool(i), "R4 random read");
        2: do_write(pool(i), 8'($urandom), int'($urandom % 3), 1'($urandom % 2),
                    1'($urandom % 2), pool((i + 1) % 64));
        3: stby_write(pool(i), 1'($urandom % 2));
        default: out_off(pool(i));
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule